// File: doc/BRIEF.md
# Dual-Request Configurable Interrupt Controller

This controller collects 32 interrupt sources and reports them to a CPU on two request lines and one wake line. Software programs it through a small 32-bit register bus. For each source it can select a trigger type, route the source to either request line, mask it and enable it for wake. Each register has separate set and clear addresses, so software can change individual bits without a read-modify-write cycle. Every register holds one bit per source.

Source inputs are asynchronous. Each passes through a two-flop synchroniser. Rising and falling transitions are then captured in sticky latches that software clears. The trigger code of a source is three bits wide and is stored across three bit-planes. Together with the mask and routing bits, the code turns each source into a pending bit on one of two pending words. A request line is high while its pending word has any bit set. Reset leaves the block in a quiet state: every source is disabled and masked, and both latches are empty.

Top module: `dual_req_intc`

## Requirements
- R1: After reset the three trigger planes, the routing, wake, mask, edge-latch and test registers all read 0. The source register reads all ones. `reqOut` and `wakeOut` are low.
- R2: Each register has a set/read offset and a clear offset: trigger plane 0 at 0x40/0x44, plane 1 at 0x48/0x4C, plane 2 at 0x50/0x54, source at 0x58/0x5C, routing at 0x60/0x64, wake at 0x68/0x6C, mask at 0x70/0x74. A 1 written to the set offset sets that bit, a 1 written to the clear offset clears it, and 0 bits leave the register unchanged.
- R3: The trigger code of source i is {plane2[i],plane1[i],plane0[i]}. The codes mean: 000 disabled, 001 rising edge, 010 falling edge, 011 either edge, 101 high level, 110 low level. Codes 100 and 111 never produce a pending condition.
- R4: A read at 0x54 returns the pending word for request 0, and a read at 0x5C returns the pending word for request 1. Writes to these offsets act as plane-2 clear and source clear.
- R5: The rising-edge latch reads at 0x78 and the falling-edge latch at 0x7C. Both capture transitions on every source whatever its code. Writing 1s to either offset clears those bits. An edge detected in the same cycle as the clear leaves its bit set.
- R6: A source with its mask bit at 0 contributes to neither pending word nor to either request output. A write to mask set (0x70) also sets the same wake bits.
- R7: A routing bit of 1 sends the source to request 0 and a 0 sends it to request 1. `reqOut[k]` is the OR of pending word k.
- R8: For level codes the pending bit follows the synchronised input and holds nothing after the input returns. An input change in front of clock edge k reaches `reqOut` after edge k+1. For edge codes the pending bit is taken from the latches.
- R9: `wakeOut` is high while any source with its wake bit set meets its trigger condition. This holds whatever the source's routing or mask.
- R10: Read data is registered. `busRdata` is loaded at the edge where `busRe` is high and holds otherwise. Offsets with no read meaning return 0.
- R11: The test register at 0x80 stores the written word and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRe | input | 1 | Read strobe |
| busRdata | output | 32 | Registered read data |
| srcIn | input | 32 | Asynchronous interrupt sources |
| reqOut | output | 2 | Request lines 0 and 1 |
| wakeOut | output | 1 | Wake request |

## Verification
The hardest case to reach from the ports is a software clear of the rising-edge latch that lands in the same cycle as a new edge on that source. The edge reaches the latch only after the synchroniser and the edge-detect stage. The bench therefore counts those registers from the negedge where it drives the input, and issues the clear write so that it lands on exactly that edge. The trigger codes are covered as a sweep: one source per code, all toggled together, with the pending words computed in the bench for both routings.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam logic [7:0] OFF_CFG0_SET = 8'h40;
  localparam logic [7:0] OFF_CFG0_CLR = 8'h44;
  localparam logic [7:0] OFF_CFG1_SET = 8'h48;
  localparam logic [7:0] OFF_CFG1_CLR = 8'h4C;
  localparam logic [7:0] OFF_CFG2_SET = 8'h50;
  localparam logic [7:0] OFF_CFG2_CLR = 8'h54;
  localparam logic [7:0] OFF_SRC_SET  = 8'h58;
  localparam logic [7:0] OFF_SRC_CLR  = 8'h5C;
  localparam logic [7:0] OFF_ASG_SET  = 8'h60;
  localparam logic [7:0] OFF_ASG_CLR  = 8'h64;
  localparam logic [7:0] OFF_WAKE_SET = 8'h68;
  localparam logic [7:0] OFF_WAKE_CLR = 8'h6C;
  localparam logic [7:0] OFF_MASK_SET = 8'h70;
  localparam logic [7:0] OFF_MASK_CLR = 8'h74;
  localparam logic [7:0] OFF_RISE     = 8'h78;
  localparam logic [7:0] OFF_FALL     = 8'h7C;
  localparam logic [7:0] OFF_TEST     = 8'h80;

  localparam int NUM_PLANES = 3;

  // Trigger codes, {plane2, plane1, plane0}
  localparam logic [2:0] TRIG_NONE = 3'b000;
  localparam logic [2:0] TRIG_RISE = 3'b001;
  localparam logic [2:0] TRIG_FALL = 3'b010;
  localparam logic [2:0] TRIG_BOTH = 3'b011;
  localparam logic [2:0] TRIG_HIGH = 3'b101;
  localparam logic [2:0] TRIG_LOW  = 3'b110;

  typedef enum logic [3:0] {
    RD_ZERO, RD_CFG0, RD_CFG1, RD_CFG2, RD_PEND0, RD_SRC, RD_PEND1,
    RD_ASG, RD_WAKE, RD_MASK, RD_RISE, RD_FALL, RD_TEST
  } rd_sel_e;

  typedef struct packed {
    logic [NUM_PLANES-1:0] cfgSet;
    logic [NUM_PLANES-1:0] cfgClr;
    logic    srcSet;
    logic    srcClr;
    logic    asgSet;
    logic    asgClr;
    logic    wakeSet;
    logic    wakeClr;
    logic    maskSet;
    logic    maskClr;
    logic    riseClr;
    logic    fallClr;
    logic    testWr;
    logic    rdEn;
    rd_sel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) pipe[s] <= '0;
        else       pipe[s] <= asyncIn;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rstN) pipe[s] <= '0;
        else       pipe[s] <= pipe[s-1];
      end
    end
  end

  assign syncOut = pipe[STAGES-1];
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobe
);
  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_ZERO;
    if (busWe) begin
      case (busAddr)
        ADDR_W'(OFF_CFG0_SET): strobe.cfgSet[0] = 1'b1;
        ADDR_W'(OFF_CFG0_CLR): strobe.cfgClr[0] = 1'b1;
        ADDR_W'(OFF_CFG1_SET): strobe.cfgSet[1] = 1'b1;
        ADDR_W'(OFF_CFG1_CLR): strobe.cfgClr[1] = 1'b1;
        ADDR_W'(OFF_CFG2_SET): strobe.cfgSet[2] = 1'b1;
        ADDR_W'(OFF_CFG2_CLR): strobe.cfgClr[2] = 1'b1;
        ADDR_W'(OFF_SRC_SET):  strobe.srcSet    = 1'b1;
        ADDR_W'(OFF_SRC_CLR):  strobe.srcClr    = 1'b1;
        ADDR_W'(OFF_ASG_SET):  strobe.asgSet    = 1'b1;
        ADDR_W'(OFF_ASG_CLR):  strobe.asgClr    = 1'b1;
        ADDR_W'(OFF_WAKE_SET): strobe.wakeSet   = 1'b1;
        ADDR_W'(OFF_WAKE_CLR): strobe.wakeClr   = 1'b1;
        ADDR_W'(OFF_MASK_SET): strobe.maskSet   = 1'b1;
        ADDR_W'(OFF_MASK_CLR): strobe.maskClr   = 1'b1;
        ADDR_W'(OFF_RISE):     strobe.riseClr   = 1'b1;
        ADDR_W'(OFF_FALL):     strobe.fallClr   = 1'b1;
        ADDR_W'(OFF_TEST):     strobe.testWr    = 1'b1;
        default: ;
      endcase
    end
    if (busRe) begin
      strobe.rdEn = 1'b1;
      case (busAddr)
        ADDR_W'(OFF_CFG0_SET): strobe.rdSel = RD_CFG0;
        ADDR_W'(OFF_CFG1_SET): strobe.rdSel = RD_CFG1;
        ADDR_W'(OFF_CFG2_SET): strobe.rdSel = RD_CFG2;
        ADDR_W'(OFF_CFG2_CLR): strobe.rdSel = RD_PEND0;
        ADDR_W'(OFF_SRC_SET):  strobe.rdSel = RD_SRC;
        ADDR_W'(OFF_SRC_CLR):  strobe.rdSel = RD_PEND1;
        ADDR_W'(OFF_ASG_SET):  strobe.rdSel = RD_ASG;
        ADDR_W'(OFF_WAKE_SET): strobe.rdSel = RD_WAKE;
        ADDR_W'(OFF_MASK_SET): strobe.rdSel = RD_MASK;
        ADDR_W'(OFF_RISE):     strobe.rdSel = RD_RISE;
        ADDR_W'(OFF_FALL):     strobe.rdSel = RD_FALL;
        ADDR_W'(OFF_TEST):     strobe.rdSel = RD_TEST;
        default:               strobe.rdSel = RD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [NUM_SRC-1:0] wData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [NUM_SRC-1:0] rData,
  output logic [1:0]         reqOut,
  output logic               wakeOut,
  output logic [NUM_SRC-1:0] maskState,
  output logic [NUM_SRC-1:0] wakeState,
  output logic [NUM_SRC-1:0] asgState,
  output logic [NUM_SRC-1:0] cfg0State
);
  localparam logic [NUM_SRC-1:0] ALL_ONES = '1;

  logic [NUM_PLANES-1:0][NUM_SRC-1:0] cfgQ;
  logic [NUM_SRC-1:0] srcQ, asgQ, wakeQ, maskQ, testQ;
  logic [NUM_SRC-1:0] riseQ, fallQ, prevQ, lvl;
  logic [NUM_SRC-1:0] riseEv, fallEv, cond, active, pend0, pend1;
  logic [NUM_SRC-1:0] rdMux;

  function automatic logic [NUM_SRC-1:0] setClr(
    input logic [NUM_SRC-1:0] q, input logic doSet, input logic doClr,
    input logic [NUM_SRC-1:0] d);
    logic [NUM_SRC-1:0] r;
    r = q;
    if (doSet) r = r | d;
    if (doClr) r = r & ~d;
    return r;
  endfunction

  // trigger code bit-planes
  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    always_ff @(posedge clk) begin
      if (!rstN) cfgQ[p] <= '0;
      else       cfgQ[p] <= setClr(cfgQ[p], strobe.cfgSet[p], strobe.cfgClr[p], wData);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ  <= ALL_ONES;
      asgQ  <= '0;
      wakeQ <= '0;
      maskQ <= '0;
      testQ <= '0;
    end else begin
      srcQ  <= setClr(srcQ, strobe.srcSet, strobe.srcClr, wData);
      asgQ  <= setClr(asgQ, strobe.asgSet, strobe.asgClr, wData);
      wakeQ <= setClr(wakeQ, strobe.wakeSet | strobe.maskSet, strobe.wakeClr, wData);
      maskQ <= setClr(maskQ, strobe.maskSet, strobe.maskClr, wData);
      if (strobe.testWr) testQ <= wData;
    end
  end

  // input synchronisation and edge capture
  intc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(srcIn), .syncOut(lvl)
  );

  assign riseEv = lvl & ~prevQ;
  assign fallEv = ~lvl & prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ <= '0;
      riseQ <= '0;
      fallQ <= '0;
    end else begin
      prevQ <= lvl;
      riseQ <= (riseQ & ~(strobe.riseClr ? wData : '0)) | riseEv;
      fallQ <= (fallQ & ~(strobe.fallClr ? wData : '0)) | fallEv;
    end
  end

  // per-source trigger evaluation
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [2:0] code;
    assign code = {cfgQ[2][i], cfgQ[1][i], cfgQ[0][i]};
    always_comb begin
      case (code)
        TRIG_RISE: cond[i] = riseQ[i];
        TRIG_FALL: cond[i] = fallQ[i];
        TRIG_BOTH: cond[i] = riseQ[i] | fallQ[i];
        TRIG_HIGH: cond[i] = lvl[i];
        TRIG_LOW:  cond[i] = ~lvl[i];
        default:   cond[i] = 1'b0;
      endcase
    end
  end

  assign active  = cond & maskQ;
  assign pend0   = active & asgQ;
  assign pend1   = active & ~asgQ;
  assign reqOut  = {|pend1, |pend0};
  assign wakeOut = |(cond & wakeQ);

  // read path
  always_comb begin
    case (strobe.rdSel)
      RD_CFG0:  rdMux = cfgQ[0];
      RD_CFG1:  rdMux = cfgQ[1];
      RD_CFG2:  rdMux = cfgQ[2];
      RD_PEND0: rdMux = pend0;
      RD_SRC:   rdMux = srcQ;
      RD_PEND1: rdMux = pend1;
      RD_ASG:   rdMux = asgQ;
      RD_WAKE:  rdMux = wakeQ;
      RD_MASK:  rdMux = maskQ;
      RD_RISE:  rdMux = riseQ;
      RD_FALL:  rdMux = fallQ;
      RD_TEST:  rdMux = testQ;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rData <= '0;
    else if (strobe.rdEn) rData <= rdMux;
  end

  assign maskState = maskQ;
  assign wakeState = wakeQ;
  assign asgState  = asgQ;
  assign cfg0State = cfgQ[0];
endmodule

// File: rtl/dual_req_intc.sv
module dual_req_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [NUM_SRC-1:0] busWdata,
  input  logic               busRe,
  output logic [NUM_SRC-1:0] busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [1:0]         reqOut,
  output logic               wakeOut
);
  strobe_t strobe;
  logic [NUM_SRC-1:0] maskQ, wakeQ, asgQ, cfg0Q;

  intc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWe(busWe), .busRe(busRe), .busAddr(busAddr), .strobe(strobe)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wData(busWdata), .srcIn(srcIn),
    .rData(busRdata), .reqOut(reqOut), .wakeOut(wakeOut),
    .maskState(maskQ), .wakeState(wakeQ), .asgState(asgQ), .cfg0State(cfg0Q)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWe,
  input logic [NUM_SRC-1:0] busWdata,
  input logic [1:0]         reqOut,
  input logic               wakeOut,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [NUM_SRC-1:0] wakeQ,
  input logic [NUM_SRC-1:0] asgQ,
  input logic [NUM_SRC-1:0] cfg0Q
);
  p_clear_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(OFF_MASK_CLR)) |=> ((maskQ & $past(busWdata)) == '0));

  p_plane_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(OFF_CFG0_CLR)) |=> ((cfg0Q & $past(busWdata)) == '0));

  p_unmask_wake_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(OFF_MASK_SET)) |=>
      ((maskQ & wakeQ & $past(busWdata)) == $past(busWdata)));

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> (reqOut == 2'b00));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> ($stable(maskQ) && $stable(asgQ) && $stable(cfg0Q)));

  p_wake_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wakeQ == '0) |-> !wakeOut);
endmodule

bind dual_req_intc intc_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
  .reqOut(reqOut), .wakeOut(wakeOut), .maskQ(maskQ), .wakeQ(wakeQ),
  .asgQ(asgQ), .cfg0Q(cfg0Q)
);

// File: tb/sim_dual_req_intc.sv
module sim_dual_req_intc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic [31:0] srcIn = '0;
  logic [1:0]  reqOut;
  logic        wakeOut;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_req_intc u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRe(busRe), .busRdata(busRdata), .srcIn(srcIn), .reqOut(reqOut), .wakeOut(wakeOut)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    v = busRdata;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  // sweep model: source i (0..7) carries trigger code i
  logic       mLvl = 1'b0;
  logic [7:0] mRise = '0, mFall = '0, mMask = '0, mAsg = '0, mWake = '0;

  function automatic logic [7:0] condWord();
    logic [7:0] c;
    for (int i = 0; i < 8; i++) begin
      case (i)
        1: c[i] = mRise[i];
        2: c[i] = mFall[i];
        3: c[i] = mRise[i] | mFall[i];
        5: c[i] = mLvl;
        6: c[i] = ~mLvl;
        default: c[i] = 1'b0;
      endcase
    end
    return c;
  endfunction

  task automatic sweepCheck(input string tag);
    logic [7:0] c, p0, p1;
    c  = condWord();
    p0 = c & mMask & mAsg;
    p1 = c & mMask & ~mAsg;
    rdChk({"R4 R3 pend0 ", tag}, 8'h54, {24'h0, p0});
    rdChk({"R4 R3 pend1 ", tag}, 8'h5C, {24'h0, p1});
    rdChk({"R5 rise ", tag}, 8'h78, {24'h0, mRise});
    rdChk({"R5 fall ", tag}, 8'h7C, {24'h0, mFall});
    check({"R7 req ", tag}, {30'h0, reqOut}, {30'h0, |p1, |p0});
    check({"R9 wake ", tag}, {31'h0, wakeOut}, {31'h0, |(c & mWake)});
  endtask

  task automatic setLevel(input logic v);
    srcIn[7:0] = v ? 8'hFF : 8'h00;
    if (v && !mLvl) mRise = 8'hFF;
    if (!v && mLvl) mFall = 8'hFF;
    mLvl = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic runSweep(input string tag);
    sweepCheck({tag, " low"});
    setLevel(1'b1);
    sweepCheck({tag, " rose"});
    wr(8'h78, 32'hFF); mRise = '0;
    sweepCheck({tag, " riseclr"});
    setLevel(1'b0);
    sweepCheck({tag, " fell"});
    wr(8'h7C, 32'hFF); mFall = '0;
    sweepCheck({tag, " fallclr"});
  endtask

  localparam logic [7:0] SET_A [6] = '{8'h40, 8'h48, 8'h50, 8'h58, 8'h60, 8'h68};
  localparam logic [7:0] CLR_A [6] = '{8'h44, 8'h4C, 8'h54, 8'h5C, 8'h64, 8'h6C};

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 reqOut", {30'h0, reqOut}, 32'h0);
    check("R1 wakeOut", {31'h0, wakeOut}, 32'h0);
    rdChk("R1 cfg0", 8'h40, 32'h0);
    rdChk("R1 cfg1", 8'h48, 32'h0);
    rdChk("R1 cfg2", 8'h50, 32'h0);
    rdChk("R1 source", 8'h58, 32'hFFFF_FFFF);
    rdChk("R1 route", 8'h60, 32'h0);
    rdChk("R1 wake", 8'h68, 32'h0);
    rdChk("R1 mask", 8'h70, 32'h0);
    rdChk("R1 rise", 8'h78, 32'h0);
    rdChk("R1 fall", 8'h7C, 32'h0);
    rdChk("R1 test", 8'h80, 32'h0);

    // R2 set/clear semantics on every pair
    for (int k = 0; k < 6; k++) begin
      exp = (k == 3) ? 32'hFFFF_FFFF : 32'h0;
      wr(CLR_A[k], 32'h0F0F_1234);
      exp = exp & ~32'h0F0F_1234;
      wr(SET_A[k], 32'hA5A5_0F0F);
      exp = exp | 32'hA5A5_0F0F;
      wr(SET_A[k], 32'h0000_F000);
      exp = exp | 32'h0000_F000;
      wr(CLR_A[k], 32'h8001_0003);
      exp = exp & ~32'h8001_0003;
      rdChk("R2 set/clear", SET_A[k], exp);
      wr(CLR_A[k], 32'hFFFF_FFFF);
      rdChk("R2 clear all", SET_A[k], 32'h0);
    end
    wr(8'h58, 32'hFFFF_FFFF);

    // R6 mask set also sets wake
    wr(8'h70, 32'h0000_3C00);
    rdChk("R6 mask set", 8'h70, 32'h0000_3C00);
    rdChk("R6 wake follows", 8'h68, 32'h0000_3C00);
    wr(8'h74, 32'hFFFF_FFFF);
    rdChk("R6 mask clr", 8'h70, 32'h0);
    rdChk("R6 wake kept", 8'h68, 32'h0000_3C00);
    wr(8'h6C, 32'hFFFF_FFFF);

    // R11 test register, R10 unmapped and hold
    wr(8'h80, 32'hDEAD_BEEF);
    rdChk("R11 test", 8'h80, 32'hDEAD_BEEF);
    @(negedge clk);
    check("R10 hold", busRdata, 32'hDEAD_BEEF);
    rdChk("R10 unmapped 0x44", 8'h44, 32'h0);
    rdChk("R10 unmapped 0x00", 8'h00, 32'h0);

    // R3 sweep: source i has code i, sources 0..3 to request 0
    wr(8'h40, 32'hAA);
    wr(8'h48, 32'hCC);
    wr(8'h50, 32'hF0);
    wr(8'h60, 32'h0F); mAsg = 8'h0F;
    wr(8'h70, 32'hFF); mMask = 8'hFF; mWake = 8'hFF;
    runSweep("asgA");
    // swapped routing, R7
    wr(8'h64, 32'hFF);
    wr(8'h60, 32'hF0); mAsg = 8'hF0;
    runSweep("asgB");
    // masked: no pending, wake still live, R6 R9
    wr(8'h74, 32'hFF); mMask = 8'h00;
    runSweep("masked");
    // writes to 0x54/0x5C act as plane-2 clear and source clear, R4
    wr(8'h54, 32'h20);
    rdChk("R4 0x54 clears plane2", 8'h50, 32'hD0);
    wr(8'h5C, 32'h1);
    rdChk("R4 0x5C clears source", 8'h58, 32'hFFFF_FFFE);

    // quiet everything
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h64, 32'hFFFF_FFFF);
    wr(8'h6C, 32'hFFFF_FFFF);
    wr(8'h74, 32'hFFFF_FFFF);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h7C, 32'hFFFF_FFFF);

    // R8 level latency on source 9, code 101, routed to request 0
    wr(8'h40, 32'h200);
    wr(8'h50, 32'h200);
    wr(8'h60, 32'h200);
    wr(8'h70, 32'h200);
    check("R8 idle", {30'h0, reqOut}, 32'h0);
    srcIn[9] = 1'b1;
    @(negedge clk);
    check("R8 after edge k", {30'h0, reqOut}, 32'h0);
    @(negedge clk);
    check("R8 after edge k+1", {30'h0, reqOut}, 32'h1);
    srcIn[9] = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 level not held", {30'h0, reqOut}, 32'h0);
    rdChk("R5 latch on level source", 8'h78, 32'h200);
    wr(8'h78, 32'h200);

    // R5 edge meeting a clear in the same cycle
    srcIn[8] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(8'h78, 32'h100);
    rdChk("R5 edge wins over clear", 8'h78, 32'h100);
    wr(8'h78, 32'h100);
    rdChk("R5 plain clear", 8'h78, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule